// File: doc/BRIEF.md
# Round-Robin Interleaved Add-and-Compare Datapath

This block adds two unsigned operands and reports whether the sum is strictly greater than a third operand. The add-then-compare path is built once per lane, with `LANES` identical lanes. A rotating phase counter sends each incoming cycle to the next lane in turn. Each lane therefore takes a new sample only once every `LANES` cycles, and its adder and comparator have that many cycles to settle. This makes the lane logic a multicycle path, which lets it use slower, smaller cells.

A phase-selected multiplexer recombines the lane results into one stream, so the block still accepts one sample and delivers one result every cycle. Everything runs on a single clock. The slow lane rate comes from one-hot load enables, not from derived clocks. The sum keeps the carry, so it is one bit wider than the operands.

Top module: `rr_addcmp`

## Requirements
- R1: When `out_vld` is high, `out_sum` equals the full-precision unsigned sum `in_a + in_b` of the sample accepted `LANES+1` cycles earlier, with width `W+1`.
- R2: When `out_vld` is high, `out_gt` is 1 exactly when that sum is strictly greater than that sample's `in_c`, zero-extended. An equal sum gives 0.
- R3: `out_vld` equals `in_vld` delayed by exactly `LANES+1` clock cycles. A sample driven before clock edge e appears on the outputs right after edge e+`LANES`.
- R4: Valid samples on every cycle give valid results on every cycle, in the order the samples arrived.
- R5: While `out_vld` is low, `out_sum` is all zeros and `out_gt` is 0.
- R6: Synchronous active-high `rst` clears the phase and every lane register. Starting at the edge after `rst` is sampled high, `out_vld`, `out_sum` and `out_gt` are 0, and samples still in flight at reset never appear.
- R7: The lane load enables are one-hot. Lane 0 loads first after reset, and the enable rotates by one lane on every cycle whether or not `in_vld` is high. Traffic with gaps therefore keeps the R3 latency and the R4 order.
- R8: Extreme operands are exact. All-ones inputs give a sum of 2^(W+1)-2. A sum that exceeds 2^W-1 compares greater than any `in_c`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Marks the current cycle's operands as a sample |
| in_a | input | W | First addend |
| in_b | input | W | Second addend |
| in_c | input | W | Comparison threshold |
| out_vld | output | 1 | Result on the outputs is valid |
| out_sum | output | W+1 | Sum including carry, zero when not valid |
| out_gt | output | 1 | Sum strictly greater than threshold, zero when not valid |

## Verification
The bench targets the compare boundary, where the sum equals the threshold or is one above it. A comparator written as greater-or-equal would report a false 1 there. It also drives sums that overflow `W` bits against a full-scale threshold. A design that dropped the carry would return a wrapped sum and clear the flag.

Gapped traffic checks that the phase does not stall on idle cycles. A counter that advanced only on valid samples would hand results out in the wrong order or at the wrong time. A reset in the middle of a stream checks that results already in flight are discarded and do not leak out after reset releases.

// File: rtl/rr_addcmp_pkg.sv
`timescale 1ns/1ps
package rr_addcmp_pkg;

  // Width of a selector over n lanes, never below one bit.
  function automatic int unsigned sel_bits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rr_phase_ctr.sv
`timescale 1ns/1ps
module rr_phase_ctr #(
  parameter int unsigned LANES = 2,
  parameter int unsigned PW    = 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [LANES-1:0] ld_en,
  output logic [PW-1:0]    sel
);

  logic [PW-1:0] phase_q;

  // Free-running modulo-LANES counter; idle cycles advance it too.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (phase_q == PW'(LANES - 1)) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + PW'(1);
    end
  end

  // One-hot load enable per lane.
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_en
      assign ld_en[g] = (phase_q == PW'(g));
    end
  endgenerate

  // The lane that loaded on the previous edge has just closed its window.
  assign sel = (phase_q == '0) ? PW'(LANES - 1) : (phase_q - PW'(1));

endmodule

// File: rtl/rr_lane.sv
`timescale 1ns/1ps
module rr_lane #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic         in_vld,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic         res_vld,
  output logic [W:0]   res_sum,
  output logic         res_gt
);

  localparam int unsigned SW = W + 1;

  logic         v_q;
  logic [W-1:0] a_q, b_q, c_q;
  logic [SW-1:0] sum_c;
  logic          gt_c;

  // Slow logic: has the full rotation window to settle.
  assign sum_c = SW'(a_q) + SW'(b_q);
  assign gt_c  = (sum_c > SW'(c_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q     <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
      c_q     <= '0;
      res_vld <= 1'b0;
      res_sum <= '0;
      res_gt  <= 1'b0;
    end else if (ld) begin
      // Retire the sample held for the last window, then take the next one.
      res_vld <= v_q;
      res_sum <= v_q ? sum_c : '0;
      res_gt  <= v_q & gt_c;
      v_q     <= in_vld;
      if (in_vld) begin
        a_q <= in_a;
        b_q <= in_b;
        c_q <= in_c;
      end
    end
  end

endmodule

// File: rtl/rr_outmux.sv
`timescale 1ns/1ps
module rr_outmux #(
  parameter int unsigned LANES = 2,
  parameter int unsigned SW    = 9,
  parameter int unsigned PW    = 1
) (
  input  logic [PW-1:0]       sel,
  input  logic [LANES-1:0]    vld_vec,
  input  logic [LANES*SW-1:0] sum_vec,
  input  logic [LANES-1:0]    gt_vec,
  output logic                out_vld,
  output logic [SW-1:0]       out_sum,
  output logic                out_gt
);

  always_comb begin
    out_vld = 1'b0;
    out_sum = '0;
    out_gt  = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (sel == PW'(k)) begin
        out_vld = vld_vec[k];
        out_sum = sum_vec[k*SW +: SW];
        out_gt  = gt_vec[k];
      end
    end
  end

endmodule

// File: rtl/rr_addcmp.sv
`timescale 1ns/1ps
module rr_addcmp
  import rr_addcmp_pkg::*;
#(
  parameter int unsigned LANES = 2,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic         out_vld,
  output logic [W:0]   out_sum,
  output logic         out_gt
);

  localparam int unsigned PW = sel_bits(LANES);
  localparam int unsigned SW = W + 1;

  logic [PW-1:0]       sel;
  logic [LANES-1:0]    ld_en;
  logic [LANES-1:0]    lane_vld;
  logic [LANES-1:0]    lane_gt;
  logic [LANES*SW-1:0] lane_sum;

  rr_phase_ctr #(.LANES(LANES), .PW(PW)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .ld_en (ld_en),
    .sel   (sel)
  );

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      rr_lane #(.W(W)) u_lane (
        .clk     (clk),
        .rst     (rst),
        .ld      (ld_en[g]),
        .in_vld  (in_vld),
        .in_a    (in_a),
        .in_b    (in_b),
        .in_c    (in_c),
        .res_vld (lane_vld[g]),
        .res_sum (lane_sum[g*SW +: SW]),
        .res_gt  (lane_gt[g])
      );
    end
  endgenerate

  rr_outmux #(.LANES(LANES), .SW(SW), .PW(PW)) u_mux (
    .sel     (sel),
    .vld_vec (lane_vld),
    .sum_vec (lane_sum),
    .gt_vec  (lane_gt),
    .out_vld (out_vld),
    .out_sum (out_sum),
    .out_gt  (out_gt)
  );

endmodule

// File: rtl/rr_addcmp_chk.sv
`timescale 1ns/1ps
module rr_addcmp_chk #(
  parameter int unsigned LANES = 2,
  parameter int unsigned W     = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_vld,
  input logic [W-1:0]     in_a,
  input logic [W-1:0]     in_b,
  input logic [W-1:0]     in_c,
  input logic             out_vld,
  input logic [W:0]       out_sum,
  input logic             out_gt,
  input logic [LANES-1:0] ld_en
);

  localparam int unsigned LAT = LANES + 1;
  localparam int unsigned SW  = W + 1;

  logic [3:0]       cnt;
  logic [LANES-1:0] prev_en;

  // Edges since reset, saturating; gates every look into the past.
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (cnt != 4'hF) cnt <= cnt + 4'd1;
    prev_en <= ld_en;
  end

  // R3
  vld_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt >= 4'(LAT)) |-> (out_vld == $past(in_vld, LAT)));

  // R1
  sum_value_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt >= 4'(LAT) && out_vld) |->
      (out_sum == (SW'($past(in_a, LAT)) + SW'($past(in_b, LAT)))));

  // R2
  gt_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt >= 4'(LAT) && out_vld) |->
      (out_gt == ((SW'($past(in_a, LAT)) + SW'($past(in_b, LAT))) > SW'($past(in_c, LAT)))));

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (out_sum == '0 && !out_gt));

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_vld && ld_en == LANES'(1)));

  // R7
  onehot_en_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(ld_en) == 1);

  // R7
  rotate_en_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt >= 4'd1) |-> (ld_en == {prev_en[LANES-2:0], prev_en[LANES-1]}));

endmodule

bind rr_addcmp rr_addcmp_chk #(.LANES(LANES), .W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_vld  (in_vld),
  .in_a    (in_a),
  .in_b    (in_b),
  .in_c    (in_c),
  .out_vld (out_vld),
  .out_sum (out_sum),
  .out_gt  (out_gt),
  .ld_en   (ld_en)
);

// File: tb/rr_addcmp_tb.sv
`timescale 1ns/1ps
module rr_addcmp_tb;

  localparam int unsigned LANES = 2;
  localparam int unsigned W     = 8;
  localparam int unsigned SW    = W + 1;
  localparam int unsigned LAT   = LANES + 1;
  localparam int unsigned RING  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_vld = 1'b0;
  logic [W-1:0]  in_a = '0, in_b = '0, in_c = '0;
  logic          out_vld;
  logic [SW-1:0] out_sum;
  logic          out_gt;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  bit    done  = 1'b0;
  string ctx   = "R6 reset";

  logic          e_vld [RING];
  logic [SW-1:0] e_sum [RING];
  logic          e_gt  [RING];

  rr_addcmp #(.LANES(LANES), .W(W)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_a    (in_a),
    .in_b    (in_b),
    .in_c    (in_c),
    .out_vld (out_vld),
    .out_sum (out_sum),
    .out_gt  (out_gt)
  );

  always #2.5 clk = ~clk;

  function automatic logic [SW-1:0] ref_sum(logic [W-1:0] a, logic [W-1:0] b);
    return SW'(a) + SW'(b);
  endfunction

  function automatic logic ref_gt(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    return ref_sum(a, b) > SW'(c);
  endfunction

  task automatic chk_bit(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s [%s] cycle %0d: got %0b expected %0b", req, what, ctx, cyc, act, exp);
    end
  endtask

  task automatic chk_sum(string req, logic [SW-1:0] act, logic [SW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s out_sum [%s] cycle %0d: got %0d expected %0d", req, ctx, cyc, act, exp);
    end
  endtask

  // One cycle: check what left the pipe, then drive and record the next input.
  task automatic step(logic r, logic v, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    int slot;
    @(negedge clk);
    slot = (cyc + RING - LAT) % RING;
    chk_bit("R3", "out_vld", out_vld, e_vld[slot]);
    if (e_vld[slot]) begin
      chk_sum("R1", out_sum, e_sum[slot]);
      chk_bit("R2", "out_gt", out_gt, e_gt[slot]);
    end else begin
      chk_sum("R5", out_sum, '0);
      chk_bit("R5", "out_gt", out_gt, 1'b0);
    end
    rst    = r;
    in_vld = v;
    in_a   = a;
    in_b   = b;
    in_c   = c;
    if (r) begin
      for (int i = 0; i < RING; i++) begin
        e_vld[i] = 1'b0;
        e_sum[i] = '0;
        e_gt[i]  = 1'b0;
      end
    end else begin
      e_vld[cyc % RING] = v;
      e_sum[cyc % RING] = v ? ref_sum(a, b) : '0;
      e_gt[cyc % RING]  = v & ref_gt(a, b, c);
    end
    cyc++;
  endtask

  task automatic rand_step(bit gaps);
    logic v;
    v = gaps ? logic'($urandom % 2) : 1'b1;
    step(1'b0, v, W'($urandom), W'($urandom), W'($urandom));
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < RING; i++) begin
      e_vld[i] = 1'b0;
      e_sum[i] = '0;
      e_gt[i]  = 1'b0;
    end
    void'($urandom(32'd4711));

    // R6: outputs stay cleared while reset is held and just after release
    ctx = "R6 reset";
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 8'hFF, 8'hFF, 8'h00);
    for (int i = 0; i < LAT + 1; i++) step(1'b0, 1'b0, '0, '0, '0);

    // R2 boundary and R8 extremes, back to back
    ctx = "R8 extremes";
    step(1'b0, 1'b1, 8'hFF, 8'hFF, 8'hFF);
    step(1'b0, 1'b1, 8'd100, 8'd55, 8'd155);
    step(1'b0, 1'b1, 8'd100, 8'd55, 8'd154);
    step(1'b0, 1'b1, 8'd0, 8'd0, 8'd0);
    step(1'b0, 1'b1, 8'd200, 8'd100, 8'hFF);
    step(1'b0, 1'b1, 8'hFF, 8'd1, 8'hFF);
    step(1'b0, 1'b1, 8'd0, 8'd0, 8'hFF);
    step(1'b0, 1'b0, 8'hAA, 8'h55, 8'h00);

    // R4: a valid sample on every cycle
    ctx = "R4 back-to-back";
    for (int i = 0; i < 300; i++) rand_step(1'b0);

    // R7: idle cycles mixed in must not disturb order or latency
    ctx = "R7 gapped";
    for (int i = 0; i < 300; i++) rand_step(1'b1);

    // R6: reset while results are in flight; none may surface afterwards
    ctx = "R6 mid-stream reset";
    step(1'b1, 1'b1, 8'd9, 8'd9, 8'd1);
    step(1'b1, 1'b1, 8'd9, 8'd9, 8'd1);
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 1'b0, 8'd3, 8'd3, 8'd3);

    ctx = "R4 after reset";
    for (int i = 0; i < 100; i++) rand_step(1'b0);

    ctx = "R3 drain";
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 1'b0, '0, '0, '0);

    finish_run();
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

endmodule